// File: doc/BRIEF.md
# Top-Region Memory Window Decoder

This block decides whether a memory request address belongs to one of up to thirty-two fixed windows in the highest sixteenth of a 32-bit address map. Each window is 8 MB wide and sits at a fixed place. Window `k` begins at the region base `0xF000_0000` plus `k` times 8 MB. A single 32-bit enable word turns windows on: bit `k` of the word enables window `k`. The block has no base or limit registers. Software picks the claimed ranges by setting bits. Neighbouring enabled windows claim one unbroken range.

Software loads the enable word through a simple write port: a strobe, a byte offset and a data word. Requests arrive with an address-valid strobe and a space flag. One clock later the block returns a registered verdict. The verdict holds a hit flag, the window index and the lowest index of the contiguous enabled run that holds the window. Downstream forwarding logic uses the run index to treat a merged span as a single target. I/O-space requests pass through the decoder but are never claimed.

Top module: `mwin_decoder`

## Requirements
- R1: After reset the enable word is zero, `rsp_valid` and `rsp_hit` are low, and no address is claimed until software writes the enable word.
- R2: A write with `cfg_wr_en` high and `cfg_addr` equal to `0x060` loads `cfg_wdata` into the enable word. A write to any other offset leaves the claimed windows unchanged.
- R3: A memory request hits exactly when address bits 31:28 equal `0xF` and the enable bit selected by address bits 27:23 is set. Bit `k` of the enable word governs the 8 MB range starting at `0xF000_0000 + k*0x80_0000`.
- R4: On a hit `rsp_win` equals address bits 27:23. On a miss `rsp_win` and `rsp_run_base` are both zero.
- R5: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. `rsp_hit` is never high while `rsp_valid` is low.
- R6: A request with `req_is_io` high (I/O space) never hits, whatever the enable word holds.
- R7: While the enable word is zero, no request hits.
- R8: On a hit, `rsp_run_base` is the smallest index `j` such that every window from `j` up to the hit window is enabled. Adjacent enabled windows therefore report the same run base.
- R9: An address whose bits 31:28 differ from `0xF` never hits, even with all thirty-two windows enabled.
- R10: A request presented in the same cycle as an enable write is decoded with the old enable word. A request in the next cycle sees the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request address valid |
| req_is_io | input | 1 | Request targets I/O space (1) or memory space (0) |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_hit | output | 1 | Request claimed |
| rsp_win | output | 5 | Window index of the claimed address |
| rsp_run_base | output | 5 | Lowest window index of the contiguous enabled run |

## Verification
The stimulus sets a scattered enable pattern made of two isolated windows and one run of three. Probes fall at the first and last byte of enabled windows and in disabled gaps, so a correct index decode can be told apart from an off-by-one boundary. Hits inside the run versus on isolated windows separate a correct run-base search from one that returns the window itself. Three kinds of request check the gating with every window enabled: I/O-space requests, addresses outside the top region, and writes to a wrong offset. A write issued in the same cycle as a request shows whether the decode uses the enable word from before or after the write.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

   typedef enum logic {
      SPACE_MEM = 1'b0,
      SPACE_IO  = 1'b1
   } mwin_space_e;

   localparam int unsigned MWIN_ADDR_W_DEF    = 32;
   localparam int unsigned MWIN_SHIFT_DEF     = 23;
   localparam int unsigned MWIN_COUNT_DEF     = 32;
   localparam int unsigned MWIN_TAG_DEF       = 'hF;
   localparam int unsigned MWIN_CFG_AW_DEF    = 12;
   localparam int unsigned MWIN_ENABLE_OFS    = 'h060;

endpackage

// File: rtl/mwin_enable_reg.sv
module mwin_enable_reg #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CFG_AW = 12,
   parameter int unsigned REG_OFS = 'h060
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] en_q
);

   localparam logic [CFG_AW-1:0] OFS = CFG_AW'(REG_OFS);

   if (REG_OFS >= (1 << CFG_AW)) begin : g_bad_ofs
      $error("mwin_enable_reg: offset does not fit the config address width");
   end

   logic sel;
   assign sel = wr_en && (wr_addr == OFS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (sel) begin
         en_q <= wr_data;
      end
   end

   AST_CFG_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> en_q == '0) else $error("enable word not cleared"); // R1

endmodule

// File: rtl/mwin_match.sv
module mwin_match #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned WIN_SHIFT = 23,
   parameter int unsigned WIN_CNT   = 32,
   parameter int unsigned REGION_TAG = 'hF,
   localparam int unsigned IDX_W    = $clog2(WIN_CNT),
   localparam int unsigned TAG_W    = ADDR_W - WIN_SHIFT - IDX_W
) (
   input  logic [ADDR_W-1:WIN_SHIFT] addr_hi,
   input  logic                      is_mem,
   input  logic [WIN_CNT-1:0]        en,
   output logic                      hit,
   output logic [IDX_W-1:0]          idx,
   output logic [IDX_W-1:0]          run_base
);

   if ((1 << IDX_W) != WIN_CNT) begin : g_bad_cnt
      $error("mwin_match: window count must be a power of two");
   end
   if (ADDR_W <= WIN_SHIFT + IDX_W) begin : g_bad_tag
      $error("mwin_match: no address bits left for the region tag");
   end
   if (REGION_TAG >= (1 << TAG_W)) begin : g_bad_tagval
      $error("mwin_match: region tag wider than its field");
   end

   logic [TAG_W-1:0] tag_f;
   logic [IDX_W-1:0] idx_f;
   logic             tag_ok;
   logic [WIN_CNT-1:0] win_sel;

   assign tag_f  = addr_hi[ADDR_W-1 -: TAG_W];
   assign idx_f  = addr_hi[WIN_SHIFT +: IDX_W];
   assign tag_ok = is_mem && (tag_f == TAG_W'(REGION_TAG));

   for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
      assign win_sel[w] = tag_ok && en[w] && (idx_f == IDX_W'(w));
   end

   assign hit = |win_sel;
   assign idx = hit ? idx_f : '0;

   logic [IDX_W-1:0] run_scan;
   always_comb begin
      run_scan = '0;
      for (int k = 0; k < WIN_CNT - 1; k++) begin
         if ((k < int'(idx_f)) && !en[k]) begin
            run_scan = IDX_W'(k + 1);
         end
      end
   end

   assign run_base = hit ? run_scan : '0;

   always_comb begin
      if (hit) begin
         AST_MATCH_ENABLED: assert (en[idx]) else $error("hit on disabled window"); // R3
      end
   end

endmodule

// File: rtl/mwin_decoder.sv
module mwin_decoder #(
   parameter int unsigned ADDR_W     = mwin_pkg::MWIN_ADDR_W_DEF,
   parameter int unsigned WIN_SHIFT  = mwin_pkg::MWIN_SHIFT_DEF,
   parameter int unsigned WIN_CNT    = mwin_pkg::MWIN_COUNT_DEF,
   parameter int unsigned REGION_TAG = mwin_pkg::MWIN_TAG_DEF,
   parameter int unsigned CFG_AW     = mwin_pkg::MWIN_CFG_AW_DEF,
   parameter int unsigned REG_OFS    = mwin_pkg::MWIN_ENABLE_OFS,
   localparam int unsigned IDX_W     = $clog2(WIN_CNT),
   localparam int unsigned TAG_W     = ADDR_W - WIN_SHIFT - IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic [CFG_AW-1:0]  cfg_addr,
   input  logic [WIN_CNT-1:0] cfg_wdata,
   input  logic               req_valid,
   input  logic               req_is_io,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_valid,
   output logic               rsp_hit,
   output logic [IDX_W-1:0]   rsp_win,
   output logic [IDX_W-1:0]   rsp_run_base
);

   import mwin_pkg::*;

   mwin_space_e      space;
   logic [WIN_CNT-1:0] en_q;
   logic             m_hit;
   logic [IDX_W-1:0] m_idx;
   logic [IDX_W-1:0] m_run;
   logic             unused_low;

   assign space      = mwin_space_e'(req_is_io);
   assign unused_low = ^req_addr[WIN_SHIFT-1:0];

   mwin_enable_reg #(
      .DATA_W (WIN_CNT),
      .CFG_AW (CFG_AW),
      .REG_OFS(REG_OFS)
   ) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .wr_addr(cfg_addr),
      .wr_data(cfg_wdata),
      .en_q   (en_q)
   );

   mwin_match #(
      .ADDR_W    (ADDR_W),
      .WIN_SHIFT (WIN_SHIFT),
      .WIN_CNT   (WIN_CNT),
      .REGION_TAG(REGION_TAG)
   ) u_match (
      .addr_hi (req_addr[ADDR_W-1:WIN_SHIFT]),
      .is_mem  (space == SPACE_MEM),
      .en      (en_q),
      .hit     (m_hit),
      .idx     (m_idx),
      .run_base(m_run)
   );

   logic take;
   assign take = req_valid && m_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_win      <= '0;
         rsp_run_base <= '0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_hit      <= take;
         rsp_win      <= take ? m_idx : '0;
         rsp_run_base <= take ? m_run : '0;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid) else $error("verdict missing"); // R5
   AST_VALID_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid) else $error("spurious verdict"); // R5
   AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_hit) else $error("hit without verdict"); // R5
   AST_IO_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_io) |=> !rsp_hit) else $error("I/O request claimed"); // R6
   AST_OUTSIDE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[ADDR_W-1 -: TAG_W] != TAG_W'(REGION_TAG)) |=> !rsp_hit)
      else $error("address outside region claimed"); // R9
   AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && en_q == '0) |=> !rsp_hit) else $error("hit with empty mask"); // R7
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_win == '0 && rsp_run_base == '0)) else $error("miss fields nonzero"); // R4
   AST_RUN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_run_base <= rsp_win) else $error("run base above window"); // R8

endmodule

// File: tb/mwin_decoder_tb_top.sv
module mwin_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr_en;
   logic [11:0] cfg_addr;
   logic [31:0] cfg_wdata;
   logic        req_valid;
   logic        req_is_io;
   logic [31:0] req_addr;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [4:0]  rsp_win;
   logic [4:0]  rsp_run_base;

   always #5 clk = ~clk;

   mwin_decoder dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_addr    (cfg_addr),
      .cfg_wdata   (cfg_wdata),
      .req_valid   (req_valid),
      .req_is_io   (req_is_io),
      .req_addr    (req_addr),
      .rsp_valid   (rsp_valid),
      .rsp_hit     (rsp_hit),
      .rsp_win     (rsp_win),
      .rsp_run_base(rsp_run_base)
   );

   int          n_tests = 0;
   int          n_fail  = 0;
   bit          mon_on  = 1'b0;
   bit          done    = 1'b0;
   logic [31:0] shadow_en = '0;
   logic [10:0] exp_q[$];
   string       tag_q[$];

   function automatic logic [10:0] model(logic [31:0] a, logic io, logic [31:0] en);
      logic       h;
      logic [4:0] w;
      logic [4:0] r;
      h = !io && (a[31:28] == 4'hF) && en[a[27:23]];
      w = h ? a[27:23] : 5'd0;
      r = 5'd0;
      if (h) begin
         r = w;
         while (r > 0 && en[r-1]) r = r - 1;
      end
      return {h, w, r};
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // one cycle of stimulus, driven at the falling edge
   task automatic step(bit wr, logic [11:0] wa, logic [31:0] wd,
                       bit rv, bit io, logic [31:0] ra, string tag);
      @(negedge clk);
      cfg_wr_en = wr; cfg_addr = wa; cfg_wdata = wd;
      req_valid = rv; req_is_io = io; req_addr = ra;
      if (rv) begin
         exp_q.push_back(model(ra, io, shadow_en));
         tag_q.push_back(tag);
      end
      if (wr && wa == 12'h060) shadow_en = wd;
   endtask

   task automatic req(logic [31:0] ra, bit io, string tag);
      step(1'b0, 12'h000, 32'h0, 1'b1, io, ra, tag);
   endtask

   task automatic wcfg(logic [11:0] wa, logic [31:0] wd);
      step(1'b1, wa, wd, 1'b0, 1'b0, 32'h0, "");
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 12'h0, 32'h0, 1'b0, 1'b0, 32'h0, "");
   endtask

   // monitor: compares each verdict against the scoreboard head
   always @(negedge clk) begin
      if (mon_on) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected verdict", 32'(rsp_hit), 32'h0);
            end else begin
               logic [10:0] e;
               string       t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({rsp_hit, rsp_win, rsp_run_base} == e, t,
                     32'({rsp_hit, rsp_win, rsp_run_base}), 32'(e));
            end
         end else begin
            check(rsp_hit == 1'b0, "R5 hit while idle", 32'(rsp_hit), 32'h0);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      req_valid = 1'b0; req_is_io = 1'b0; req_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1 reset valid", 32'(rsp_valid), 32'h0);
      check(rsp_hit == 1'b0, "R1 reset hit", 32'(rsp_hit), 32'h0);
      mon_on = 1'b1;

      // R1 / R7: nothing claimed before the enable word is written
      req(32'hF000_0000, 1'b0, "R1 R7 no decode after reset");
      req(32'hFFFF_FFFF, 1'b0, "R7 empty mask top window");
      // R2: wrong offset ignored
      wcfg(12'h064, 32'hFFFF_FFFF);
      req(32'hF000_0000, 1'b0, "R2 write to wrong offset ignored");
      // R2: proper write, windows 0, 2, 9, 10, 11
      wcfg(12'h060, 32'h0000_0E05);
      req(32'hF000_0000, 1'b0, "R3 window 0 first byte");
      req(32'hF07F_FFFF, 1'b0, "R3 window 0 last byte");
      req(32'hF080_0000, 1'b0, "R3 window 1 disabled");
      req(32'hF100_0004, 1'b0, "R4 window 2 index");
      req(32'hF480_0000, 1'b0, "R8 run start window 9");
      req(32'hF500_0000, 1'b0, "R8 run middle window 10");
      req(32'hF5FF_FFFC, 1'b0, "R8 run end window 11");
      req(32'hF600_0000, 1'b0, "R3 window 12 disabled");
      idle(2);
      req(32'hF000_0000, 1'b1, "R6 I/O request ignored");
      // all windows on
      wcfg(12'h060, 32'hFFFF_FFFF);
      req(32'hFFFF_FFFF, 1'b0, "R8 window 31 run base 0");
      req(32'hE000_0000, 1'b0, "R9 region below top");
      req(32'h7800_0000, 1'b0, "R9 tag mismatch");
      req(32'hF880_0000, 1'b1, "R6 I/O with all windows");
      // R10: write zero in same cycle as a request
      step(1'b1, 12'h060, 32'h0, 1'b1, 1'b0, 32'hF880_0000, "R10 old word used");
      req(32'hF880_0000, 1'b0, "R10 new word used");
      // R2: wrong offset cannot re-enable
      wcfg(12'h000, 32'hFFFF_FFFF);
      req(32'hF880_0000, 1'b0, "R2 offset 0 ignored");
      wcfg(12'h060, 32'h8000_0001);
      req(32'hFF80_0000, 1'b0, "R8 isolated top window");
      req(32'hF000_0000, 1'b0, "R3 window 0 restored");
      idle(4);
      check(exp_q.size() == 0, "R5 all verdicts returned", 32'(exp_q.size()), 32'h0);
      finish_run();
   end

endmodule